// File: doc/BRIEF.md
# GPIO pin function and level controller

This block is the register-mapped control logic for a set of general-purpose pins (54 by default), grouped into a low bank of 32 pins and a high bank that holds the rest. Software programs a three-bit function code for each pin and moves output levels through write-one-to-set and write-one-to-clear locations. It reads those levels back from read-only locations. Four plain pull-configuration words sit alongside. From this state the block drives an output-value vector and an output-enable vector for the pads.

The block also picks which of two host controllers owns a card interface. The choice follows the function codes of six consecutive card pins (48 to 53 by default). Whenever those pins are all inputs, host A is chosen. Whenever they are all in the first alternate function (code 4), host B is chosen. Any other mix leaves the current choice unchanged, so the selector is sticky. Software normally reprograms the six pins with several word writes, and the selector ignores the mixed states in between. The register bus is a plain single-cycle strobe interface. It has no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `gpio_fn_ctrl`

## Requirements
- R1: Pin n's function code is held in function word n/10 (byte offset 4*(n/10), words at 0x00 to 0x14), in bits 3*(n mod 10)+2 down to 3*(n mod 10). Writing a word updates all of its fields. Reading it returns them. Bits 30 and 31, and fields for pins above the last pin, read as zero and are not stored.
- R2: Function codes are 0 input, 1 output, 2 to 7 alternate functions (4 is the first alternate function). The output enable bit of pin n is 1 exactly when its code is 1.
- R3: A write to 0x1C (pins 0 to 31) or 0x20 (pins 32 and up, bit 0 = pin 32) ORs the written data into that bank's level register.
- R4: A write to 0x28 (low bank) or 0x2C (high bank) clears, in that bank's level register, each bit that is 1 in the written data.
- R5: Set and clear writes change the level register whatever the pin's function code is. The output value of pin n equals its level bit while its code is 1, and is 0 otherwise.
- R6: Reading 0x1C, 0x20, 0x28 or 0x2C returns zero. The level registers read at 0x34 (low bank) and 0x38 (high bank), and writes to these two offsets have no effect.
- R7: Offsets 0x40 through 0x8C, and every other unmapped or non-word-aligned offset, read as zero, and writes to them have no effect.
- R8: The pull words at 0xE4, 0xE8, 0xEC and 0xF0 are full 32-bit read/write registers. They reset to 0xAAA95555, 0xA0AAAAAA, 0x50AAA95A and 0x00055555 respectively.
- R9: After reset, all function codes and both level registers are zero, all output enables and outputs are 0, and the card selector output (card_to_b) is 0, meaning host A.
- R10: After each function-word write, card_to_b becomes 0 if pins 48 to 53 all hold code 0, and becomes 1 if they all hold code 4. Any other combination keeps the previous value.
- R11: High-bank level bits beyond the last pin (bits 22 to 31 by default) read as zero at 0x38, and set or clear data in those bit positions has no effect.
- R12: Read data appears on bus_rdata after the clock edge that samples bus_ren and holds until the next read. A write takes effect on the edge that samples bus_wen. card_to_b changes on the edge after the one that captured the function-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wen | input | 1 | Write strobe, one access per cycle |
| bus_ren | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_out | output | 54 | Output value per pin |
| pin_oe | output | 54 | Output enable per pin |
| card_to_b | output | 1 | Card interface owner: 0 host A, 1 host B |

## Verification
Random function-word writes are biased so that the six card pins often land all-input, all-ALT0 or a mix. This separates the two switching patterns from the sticky hold, and the directed sequence walks through both partial-write orderings. Random set and clear traffic runs against random function codes, which tells apart a level that moves for every pin from an output that follows it only for pins coded as outputs. Writes to read-only, event and unmapped offsets are each followed by read-backs of the levels, function words and pull words, to prove they changed nothing.

// File: rtl/gpio_fn_pkg.sv
package gpio_fn_pkg;
  localparam int unsigned FW  = 3;   // bits per function field
  localparam int unsigned FPW = 10;  // fields per function word

  typedef enum logic [2:0] {
    FN_IN   = 3'd0,
    FN_OUT  = 3'd1,
    FN_ALT5 = 3'd2,
    FN_ALT4 = 3'd3,
    FN_ALT0 = 3'd4,
    FN_ALT1 = 3'd5,
    FN_ALT2 = 3'd6,
    FN_ALT3 = 3'd7
  } fn_code_e;

  localparam logic [7:0] OFS_SET_LO = 8'h1C;
  localparam logic [7:0] OFS_SET_HI = 8'h20;
  localparam logic [7:0] OFS_CLR_LO = 8'h28;
  localparam logic [7:0] OFS_CLR_HI = 8'h2C;
  localparam logic [7:0] OFS_LEV_LO = 8'h34;
  localparam logic [7:0] OFS_LEV_HI = 8'h38;
  localparam logic [7:0] OFS_PULL0  = 8'hE4;
  localparam int unsigned PULL_WORDS = 4;

  function automatic logic [31:0] pull_reset(input int unsigned k);
    case (k)
      0:       return 32'hAAA9_5555;
      1:       return 32'hA0AA_AAAA;
      2:       return 32'h50AA_A95A;
      default: return 32'h0005_5555;
    endcase
  endfunction
endpackage

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_fn_pkg::*;
#(
  parameter int unsigned NPINS = 54,
  parameter int unsigned NWORDS = (NPINS + FPW - 1) / FPW,
  parameter int unsigned WIDX = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WIDX-1:0]       wr_idx,
  input  logic [31:0]           wr_data,
  input  logic [WIDX-1:0]       rd_idx,
  output logic [31:0]           rd_word,
  output logic [NPINS*FW-1:0]   codes
);
  logic [FW-1:0] code_q [NPINS];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int unsigned WSEL = p / FPW;
    localparam int unsigned FSEL = p % FPW;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q[p] <= FN_IN;
      else if (wr_en && wr_idx == WIDX'(WSEL)) code_q[p] <= wr_data[FSEL*FW +: FW];
    end
    assign codes[p*FW +: FW] = code_q[p];
  end

  always_comb begin
    rd_word = '0;
    for (int f = 0; f < FPW; f++) begin
      if (int'(rd_idx) * FPW + f < NPINS)
        rd_word[f*FW +: FW] = code_q[int'(rd_idx) * FPW + f];
    end
  end
endmodule

// File: rtl/gpio_level_bank.sv
module gpio_level_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level <= '0;
    else if (set_we) level <= level | wdata;
    else if (clr_we) level <= level & ~wdata;
  end
endmodule

// File: rtl/gpio_card_route.sv
module gpio_card_route
  import gpio_fn_pkg::*;
#(
  parameter int unsigned NPINS = 54,
  parameter int unsigned FIRST = 48,
  parameter int unsigned COUNT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fsel_written,
  input  logic [NPINS*FW-1:0] codes,
  output logic                to_b
);
  logic upd_q, all_in, all_alt0;

  always_comb begin
    all_in   = 1'b1;
    all_alt0 = 1'b1;
    for (int i = 0; i < COUNT; i++) begin
      if (codes[(FIRST+i)*FW +: FW] != FN_IN)   all_in   = 1'b0;
      if (codes[(FIRST+i)*FW +: FW] != FN_ALT0) all_alt0 = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      to_b  <= 1'b0;
    end else begin
      upd_q <= fsel_written;
      if (upd_q) begin
        if (all_in)        to_b <= 1'b0;
        else if (all_alt0) to_b <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_fn_ctrl.sv
module gpio_fn_ctrl
  import gpio_fn_pkg::*;
#(
  parameter int unsigned NPINS     = 54,
  parameter int unsigned LO_PINS   = 32,
  parameter int unsigned CARD_PIN0 = 48,
  parameter int unsigned CARD_PINS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wen,
  input  logic             bus_ren,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             card_to_b
);
  localparam int unsigned HI_PINS = NPINS - LO_PINS;
  localparam int unsigned NWORDS  = (NPINS + FPW - 1) / FPW;
  localparam int unsigned WIDX    = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic                aligned, fsel_hit, pull_hit;
  logic [5:0]          word_no;
  logic [1:0]          pull_idx;
  logic [31:0]         fsel_rd, rmux;
  logic [NPINS*FW-1:0] codes;
  logic [LO_PINS-1:0]  lev_lo;
  logic [HI_PINS-1:0]  lev_hi;
  logic [31:0]         pull_q [PULL_WORDS];
  logic [7:0]          pull_ofs;

  assign aligned  = bus_addr[1:0] == 2'b00;
  assign word_no  = bus_addr[7:2];
  assign fsel_hit = aligned && (word_no < 6'(NWORDS));
  assign pull_ofs = bus_addr - OFS_PULL0;
  assign pull_hit = aligned && (bus_addr >= OFS_PULL0) && (pull_ofs < 8'(PULL_WORDS * 4));
  assign pull_idx = pull_ofs[3:2];

  gpio_fsel_regs #(.NPINS(NPINS), .NWORDS(NWORDS), .WIDX(WIDX)) u_fsel (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wen && fsel_hit), .wr_idx(word_no[WIDX-1:0]), .wr_data(bus_wdata),
    .rd_idx(word_no[WIDX-1:0]), .rd_word(fsel_rd), .codes(codes)
  );

  gpio_level_bank #(.WIDTH(LO_PINS)) u_lev_lo (
    .clk(clk), .rst_n(rst_n),
    .set_we(bus_wen && bus_addr == OFS_SET_LO),
    .clr_we(bus_wen && bus_addr == OFS_CLR_LO),
    .wdata(bus_wdata[LO_PINS-1:0]), .level(lev_lo)
  );

  gpio_level_bank #(.WIDTH(HI_PINS)) u_lev_hi (
    .clk(clk), .rst_n(rst_n),
    .set_we(bus_wen && bus_addr == OFS_SET_HI),
    .clr_we(bus_wen && bus_addr == OFS_CLR_HI),
    .wdata(bus_wdata[HI_PINS-1:0]), .level(lev_hi)
  );

  gpio_card_route #(.NPINS(NPINS), .FIRST(CARD_PIN0), .COUNT(CARD_PINS)) u_route (
    .clk(clk), .rst_n(rst_n),
    .fsel_written(bus_wen && fsel_hit), .codes(codes), .to_b(card_to_b)
  );

  for (genvar k = 0; k < PULL_WORDS; k++) begin : g_pull
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pull_q[k] <= pull_reset(k);
      else if (bus_wen && pull_hit && pull_idx == 2'(k)) pull_q[k] <= bus_wdata;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pin_oe[p] = codes[p*FW +: FW] == FN_OUT;
  end
  assign pin_out = {lev_hi, lev_lo} & pin_oe;

  always_comb begin
    rmux = '0;
    if (fsel_hit)                      rmux = fsel_rd;
    else if (pull_hit)                 rmux = pull_q[pull_idx];
    else if (bus_addr == OFS_LEV_LO)   rmux = 32'(lev_lo);
    else if (bus_addr == OFS_LEV_HI)   rmux = 32'(lev_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rmux;
  end
endmodule

// File: rtl/gpio_fn_ctrl_chk.sv
module gpio_fn_ctrl_chk
  import gpio_fn_pkg::*;
#(
  parameter int unsigned NPINS = 54
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_wen,
  input logic             bus_ren,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             card_to_b
);
  logic fsel_wr, wo_rd, ev_rd, hi_rd;
  assign fsel_wr = bus_wen && bus_addr[1:0] == 2'b00 && bus_addr < 8'h18;
  assign wo_rd   = bus_ren && (bus_addr == OFS_SET_LO || bus_addr == OFS_SET_HI ||
                               bus_addr == OFS_CLR_LO || bus_addr == OFS_CLR_HI);
  assign ev_rd   = bus_ren && bus_addr >= 8'h40 && bus_addr <= 8'h8C;
  assign hi_rd   = bus_ren && bus_addr == OFS_LEV_HI;

  p_out_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
  p_oe_by_fsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != $past(pin_oe)) |-> $past(fsel_wr));
  p_out_by_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out != $past(pin_out)) |-> $past(bus_wen));
  p_route_after_fsel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (card_to_b != $past(card_to_b)) |-> $past(fsel_wr, 2));
  p_wo_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wo_rd) |-> bus_rdata == 32'h0);
  p_event_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_rd) |-> bus_rdata == 32'h0);
  p_hi_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hi_rd) |-> bus_rdata[31:22] == 10'h0);
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_ren) |-> $stable(bus_rdata));
endmodule

bind gpio_fn_ctrl gpio_fn_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_ren(bus_ren),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .card_to_b(card_to_b)
);

// File: tb/tb_gpio_fn_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_fn_ctrl;
  localparam int NP = 54;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wen = 1'b0, bus_ren = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_out, pin_oe;
  logic card_to_b;

  int n_chk = 0, n_fail = 0;
  logic [2:0]  m_code [NP];
  logic [31:0] m_lo, m_pull [4];
  logic [21:0] m_hi;
  logic        m_route;

  always #2.5 clk = ~clk;

  gpio_fn_ctrl dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word(input int w);
    logic [31:0] v = '0;
    for (int f = 0; f < 10; f++) if (w*10 + f < NP) v[f*3 +: 3] = m_code[w*10 + f];
    return v;
  endfunction

  function automatic logic [NP-1:0] m_oe();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = (m_code[p] == 3'd1);
    return v;
  endfunction

  task automatic m_apply(input logic [7:0] a, input logic [31:0] d);
    if (a[1:0] == 2'b00 && a < 8'h18) begin
      for (int f = 0; f < 10; f++) if (a/4*10 + f < NP) m_code[a/4*10 + f] = d[f*3 +: 3];
    end else if (a == 8'h1C) m_lo = m_lo | d;
    else if (a == 8'h20) m_hi = m_hi | d[21:0];
    else if (a == 8'h28) m_lo = m_lo & ~d;
    else if (a == 8'h2C) m_hi = m_hi & ~d[21:0];
    else if (a[1:0] == 2'b00 && a >= 8'hE4 && a <= 8'hF0) m_pull[(a - 8'hE4) / 4] = d;
  endtask

  function automatic logic m_route_next();
    logic ai = 1'b1, a0 = 1'b1;
    for (int p = 48; p < 54; p++) begin
      if (m_code[p] != 3'd0) ai = 1'b0;
      if (m_code[p] != 3'd4) a0 = 1'b0;
    end
    return ai ? 1'b0 : (a0 ? 1'b1 : m_route);
  endfunction

  task automatic check_pins(input string req);
    check({req, " oe"}, 64'(pin_oe), 64'(m_oe()));
    check({req, " out"}, 64'(pin_out), 64'({m_hi, m_lo} & m_oe()));
    check({req, " route"}, 64'(card_to_b), 64'(m_route));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wen = 1'b0;
    m_apply(a, d);
    check_pins("R5");  // route still old here (R12)
    if (a[1:0] == 2'b00 && a < 8'h18) begin
      m_route = m_route_next();
      @(posedge clk); @(negedge clk);
      check("R10/R12 route", 64'(card_to_b), 64'(m_route));
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_ren = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic check_state(input string req);
    logic [31:0] v;
    for (int w = 0; w < 6; w++) begin rd(8'(w*4), v); check({req, " R1 fsel"}, 64'(v), 64'(m_word(w))); end
    rd(8'h34, v); check({req, " R6 lev_lo"}, 64'(v), 64'(m_lo));
    rd(8'h38, v); check({req, " R11 lev_hi"}, 64'(v), 64'({10'h0, m_hi}));
    for (int k = 0; k < 4; k++) begin rd(8'(8'hE4 + k*4), v); check({req, " R8 pull"}, 64'(v), 64'(m_pull[k])); end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'h00C0FFEE));
    for (int p = 0; p < NP; p++) m_code[p] = 3'd0;
    m_lo = '0; m_hi = '0; m_route = 1'b0;
    for (int k = 0; k < 4; k++) m_pull[k] = gpio_fn_pkg::pull_reset(k);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9 reset state, R8 reset pull values
    check_pins("R9");
    check_state("R9");
    check("R8 pull0 reset", 64'(m_pull[0]), 64'h0000_0000_AAA9_5555);

    // R1 packing and unused bits
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R1 word5 unused fields", 64'(v), 64'h0000_0FFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check("R1 bits 31:30 zero", 64'(v), 64'h3FFF_FFFF);

    // R2 / R3 / R5: pin 3 output, pin 4 input; level moves regardless of code
    wr(8'h00, 32'h0000_0200);           // pin3 code 1
    wr(8'h1C, 32'h0000_0018);           // set bits 3,4
    check("R2 oe pin3", 64'(pin_oe[3]), 64'd1);
    check("R5 out pin4 gated", 64'(pin_out[4]), 64'd0);
    rd(8'h34, v); check("R3 lev_lo set", 64'(v), 64'h18);
    wr(8'h28, 32'h0000_0008);
    check("R4 out pin3 cleared", 64'(pin_out[3]), 64'd0);
    rd(8'h34, v); check("R4 lev_lo clr", 64'(v), 64'h10);

    // R11 high bank unused bits
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h38, v); check("R11 lev_hi set", 64'(v), 64'h003F_FFFF);
    wr(8'h2C, 32'hFFC0_0001);
    rd(8'h38, v); check("R11 lev_hi clr", 64'(v), 64'h003F_FFFE);

    // R6 write-only reads zero, level read-only
    rd(8'h1C, v); check("R6 set reads 0", 64'(v), 64'h0);
    rd(8'h2C, v); check("R6 clr reads 0", 64'(v), 64'h0);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h38, 32'h0);
    check_state("R6 after level write");

    // R7 event range and unmapped offsets
    for (int a = 8'h40; a <= 8'h8C; a += 4) begin
      wr(8'(a), 32'hFFFF_FFFF);
      rd(8'(a), v); check("R7 event reads 0", 64'(v), 64'h0);
    end
    wr(8'hFC, 32'h1234_5678); wr(8'hE5, 32'h0); wr(8'h01, 32'hFFFF_FFFF);
    rd(8'hE5, v); check("R7 misaligned reads 0", 64'(v), 64'h0);
    check_state("R7 after ignored writes");

    // R8 pull read/write
    wr(8'hEC, 32'hDEAD_BEEF);
    check_state("R8 pull write");

    // R10 directed routing sequence
    wr(8'h10, 32'h0000_0000); wr(8'h14, 32'h0000_0000);
    check("R10 all input -> A", 64'(card_to_b), 64'd0);
    wr(8'h10, 32'h2400_0000);  // pins 48,49 ALT0: mix, hold A
    check("R10 mix holds A", 64'(card_to_b), 64'd0);
    wr(8'h14, 32'h0000_0924);  // pins 50-53 ALT0: all ALT0
    check("R10 all ALT0 -> B", 64'(card_to_b), 64'd1);
    wr(8'h14, 32'h0000_0921);  // pin50 output: mix, hold B
    check("R10 mix holds B", 64'(card_to_b), 64'd1);
    wr(8'h14, 32'h0);          // 50-53 input, 48/49 ALT0: hold B
    check("R10 partial input holds B", 64'(card_to_b), 64'd1);
    wr(8'h10, 32'h0);          // all input -> A
    check("R10 back to A", 64'(card_to_b), 64'd0);

    // Constrained random traffic
    for (int it = 0; it < 400; it++) begin
      int sel = int'($urandom_range(0, 9));
      logic [31:0] d = $urandom;
      if (sel <= 2) begin
        int w = int'($urandom_range(0, 5));
        if (w >= 4 && $urandom_range(0, 1) == 1) begin
          logic [2:0] c = ($urandom_range(0, 1) == 1) ? 3'd4 : 3'd0;
          if (w == 4) d = {2'b0, c, c, d[23:0]};
          else d = {d[31:12], c, c, c, c};
        end
        wr(8'(w*4), d);
      end else if (sel <= 4) wr(8'h1C, d);
      else if (sel == 5) wr(8'h20, d);
      else if (sel == 6) wr(8'h28, d);
      else if (sel == 7) wr(8'h2C, d);
      else if (sel == 8) wr(8'(8'hE4 + 4*$urandom_range(0, 3)), d);
      else wr(8'(8'h40 + 4*$urandom_range(0, 19)), d);
      if (it % 40 == 0) check_state("random");
    end
    check_state("final");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule